// File: doc/BRIEF.md
# Read Address Sequence Command Detector

This block watches the completed read cycles of an asynchronous memory bus, after they have been brought into a synchronous clock domain. It turns two fixed sequences of six read addresses into command pulses. The first five addresses are the same in both sequences. The sixth address picks the command: one value requests a save of the volatile array into non-volatile storage (STORE), and the other requests a restore from non-volatile storage (RECALL). Each command appears as a single-cycle pulse for a controller that carries out the operation.

Progress through a sequence is counted only on the cycles where the read-complete strobe is high. Any of the following abandons a partial sequence and issues no command:
- a write,
- a read at an address that does not fit the next step,
- the controller's busy signal.

A read at the opening address always starts a new attempt, even when it is the read that caused an abort. Cycles with no strobe do not change the progress. The output-enable level has no effect, because it is not an input of the block.

Top module: `read_seq_cmd`

## Requirements
- R1: While reset (`rstN` low) is active, and in the first cycle after it, `storePulse` and `recallPulse` are low and no sequence is in progress.
- R2: Reads at 0x0000, 0x1555, 0x0AAA, 0x1FFF, 0x10F0 and then 0x0F0F set `storePulse` high for the one clock cycle that follows the clock edge at which the sixth read's `rdDone` is sampled.
- R3: The same five opening reads followed by a read at 0x0F0E set `recallPulse` high with the same timing as R2.
- R4: A read whose address does not match the next expected step ends the sequence. The remaining steps then produce no pulse.
- R5: `wrStrobe` high on any clock edge ends the sequence. When `wrStrobe` and `rdDone` are high on the same edge, the write wins and the read does not count.
- R6: A read at 0x0000 that does not match the next expected step still counts as step one of a new sequence.
- R7: While `busy` is high, reads are ignored, no pulse is issued and the sequence returns to its start.
- R8: Cycles without `rdDone` do not affect the progress of a sequence. Each pulse lasts exactly one cycle, and the two pulses are never high together.
- R9: The address is compared on all 15 bits. An opening address with bit 14 set does not match.
- R10: A sixth read at an address other than 0x0F0F or 0x0F0E issues no pulse. If that address is 0x0000, it starts a new sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rstN | input | 1 | Active-low synchronous reset |
| busy | input | 1 | Controller busy; clears the sequence and blocks detection |
| rdDone | input | 1 | One cycle per completed bus read |
| wrStrobe | input | 1 | One cycle per bus write |
| addr | input | ADDR_W (15) | Bus address, valid with `rdDone` |
| storePulse | output | 1 | Single-cycle STORE command |
| recallPulse | output | 1 | Single-cycle RECALL command |

## Verification
The assertions check the following on every cycle:
- the two pulses are exclusive and never last longer than one cycle;
- no pulse follows an edge on which `busy` or `wrStrobe` was high;
- every pulse follows a read at the matching final address.

Only the bench's scenarios can show the ordering behaviour: a sequence aborted by a wrong address or a write, a restart at 0x0000, a sixth address that is wrong, and idle gaps between reads. The bench does this with directed cases and random streams that favour the magic addresses, compared against a model of the step sequence.

// File: rtl/rsc_pkg.sv
package rsc_pkg;
  localparam int SEQ_LEN = 6;
  localparam int STEP_W = $clog2(SEQ_LEN);
  localparam int KEY_W = 15;
  localparam logic [KEY_W-1:0] STORE_KEY = 15'h0F0F;
  localparam logic [KEY_W-1:0] RECALL_KEY = 15'h0F0E;

  typedef struct packed {
    logic clear;
    logic advance;
    logic restart;
    logic fireStore;
    logic fireRecall;
  } rsc_strobe_t;

  // Expected address for each step of the shared opening
  function automatic logic [KEY_W-1:0] seqAddr(logic [STEP_W-1:0] idx);
    case (idx)
      3'd0: seqAddr = 15'h0000;
      3'd1: seqAddr = 15'h1555;
      3'd2: seqAddr = 15'h0AAA;
      3'd3: seqAddr = 15'h1FFF;
      3'd4: seqAddr = 15'h10F0;
      default: seqAddr = 15'h7FFF;
    endcase
  endfunction
endpackage

// File: rtl/rsc_datapath.sv
module rsc_datapath
  import rsc_pkg::*;
#(
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  rsc_strobe_t       strb,
  output logic              prefixHit,
  output logic              startHit,
  output logic              storeHit,
  output logic              recallHit,
  output logic              lastStep,
  output logic              storePulse,
  output logic              recallPulse
);
  logic [STEP_W-1:0] stepQ;

  always_comb begin
    prefixHit = (addr == ADDR_W'(seqAddr(stepQ)));
    startHit  = (addr == '0);
    storeHit  = (addr == ADDR_W'(STORE_KEY));
    recallHit = (addr == ADDR_W'(RECALL_KEY));
    lastStep  = (stepQ == STEP_W'(SEQ_LEN - 1));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stepQ       <= '0;
      storePulse  <= 1'b0;
      recallPulse <= 1'b0;
    end else begin
      storePulse  <= strb.fireStore;
      recallPulse <= strb.fireRecall;
      if (strb.clear)        stepQ <= '0;
      else if (strb.advance) stepQ <= stepQ + 1'b1;
      else if (strb.restart) stepQ <= STEP_W'(1);
    end
  end
endmodule

// File: rtl/rsc_control.sv
module rsc_control
  import rsc_pkg::*;
(
  input  logic        busy,
  input  logic        rdDone,
  input  logic        wrStrobe,
  input  logic        prefixHit,
  input  logic        startHit,
  input  logic        storeHit,
  input  logic        recallHit,
  input  logic        lastStep,
  output rsc_strobe_t strb
);
  always_comb begin
    strb = '0;
    if (busy || wrStrobe) begin
      strb.clear = 1'b1;
    end else if (rdDone) begin
      if (lastStep) begin
        if (storeHit) begin
          strb.fireStore = 1'b1;
          strb.clear     = 1'b1;
        end else if (recallHit) begin
          strb.fireRecall = 1'b1;
          strb.clear      = 1'b1;
        end else if (startHit) begin
          strb.restart = 1'b1;
        end else begin
          strb.clear = 1'b1;
        end
      end else if (prefixHit) begin
        strb.advance = 1'b1;
      end else if (startHit) begin
        strb.restart = 1'b1;
      end else begin
        strb.clear = 1'b1;
      end
    end
  end
endmodule

// File: rtl/read_seq_cmd.sv
module read_seq_cmd
  import rsc_pkg::*;
#(
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busy,
  input  logic              rdDone,
  input  logic              wrStrobe,
  input  logic [ADDR_W-1:0] addr,
  output logic              storePulse,
  output logic              recallPulse
);
  rsc_strobe_t strb;
  logic prefixHit, startHit, storeHit, recallHit, lastStep;

  rsc_control i_ctrl (
    .busy(busy), .rdDone(rdDone), .wrStrobe(wrStrobe),
    .prefixHit(prefixHit), .startHit(startHit), .storeHit(storeHit),
    .recallHit(recallHit), .lastStep(lastStep), .strb(strb)
  );

  rsc_datapath #(.ADDR_W(ADDR_W)) i_dp (
    .clk(clk), .rstN(rstN), .addr(addr), .strb(strb),
    .prefixHit(prefixHit), .startHit(startHit), .storeHit(storeHit),
    .recallHit(recallHit), .lastStep(lastStep),
    .storePulse(storePulse), .recallPulse(recallPulse)
  );
endmodule

// File: rtl/read_seq_cmd_chk.sv
module read_seq_cmd_chk #(
  parameter int ADDR_W = 15
) (
  input logic              clk,
  input logic              rstN,
  input logic              busy,
  input logic              rdDone,
  input logic              wrStrobe,
  input logic [ADDR_W-1:0] addr,
  input logic              storePulse,
  input logic              recallPulse
);
  assert_exclusive_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(storePulse && recallPulse));
  assert_store_single_R8: assert property (@(posedge clk) disable iff (!rstN)
    storePulse |=> !storePulse);
  assert_recall_single_R8: assert property (@(posedge clk) disable iff (!rstN)
    recallPulse |=> !recallPulse);
  assert_busy_blocks_R7: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> !(storePulse || recallPulse));
  assert_write_blocks_R5: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe |=> !(storePulse || recallPulse));
  assert_store_cause_R2: assert property (@(posedge clk) disable iff (!rstN)
    storePulse |-> $past(rdDone && !wrStrobe && !busy && addr == ADDR_W'(15'h0F0F)));
  assert_recall_cause_R3: assert property (@(posedge clk) disable iff (!rstN)
    recallPulse |-> $past(rdDone && !wrStrobe && !busy && addr == ADDR_W'(15'h0F0E)));
endmodule

bind read_seq_cmd read_seq_cmd_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .rdDone(rdDone), .wrStrobe(wrStrobe),
  .addr(addr), .storePulse(storePulse), .recallPulse(recallPulse)
);

// File: tb/test_read_seq_cmd.sv
module test_read_seq_cmd;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busy = 1'b0, rdDone = 1'b0, wrStrobe = 1'b0;
  logic [14:0] addr = '0;
  logic storePulse, recallPulse;
  int checks = 0, errors = 0;
  int mStep = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  read_seq_cmd i_read_seq_cmd (
    .clk(clk), .rstN(rstN), .busy(busy), .rdDone(rdDone), .wrStrobe(wrStrobe),
    .addr(addr), .storePulse(storePulse), .recallPulse(recallPulse)
  );

  function automatic logic [14:0] keyAt(int i);
    case (i)
      0: return 15'h0000;
      1: return 15'h1555;
      2: return 15'h0AAA;
      3: return 15'h1FFF;
      4: return 15'h10F0;
      5: return 15'h0F0F;
      6: return 15'h0F0E;
      default: return 15'h4000;
    endcase
  endfunction

  task automatic check(string tag, logic actS, logic actR, logic expS, logic expR);
    checks++;
    if (actS !== expS || actR !== expR) begin
      errors++;
      $display("FAIL %s: store/recall=%b%b expected %b%b", tag, actS, actR, expS, expR);
    end
  endtask

  // Drive one cycle at the falling edge, sample at the next falling edge
  task automatic cyc(logic rd, logic wr, logic bz, logic [14:0] a, string tag);
    logic expS = 1'b0, expR = 1'b0;
    rdDone = rd; wrStrobe = wr; busy = bz; addr = a;
    if (bz || wr) mStep = 0;
    else if (rd) begin
      if (mStep == 5) begin
        expS = (a == 15'h0F0F);
        expR = (a == 15'h0F0E);
        mStep = (a == 15'h0000) ? 1 : 0;
      end else if (a == keyAt(mStep)) mStep++;
      else mStep = (a == 15'h0000) ? 1 : 0;
    end
    @(negedge clk);
    check(tag, storePulse, recallPulse, expS, expR);
  endtask

  task automatic rd(logic [14:0] a, string tag); cyc(1, 0, 0, a, tag); endtask
  task automatic idle(string tag); cyc(0, 0, 0, 15'h0, tag); endtask
  task automatic prefix(string tag);
    for (int i = 0; i < 5; i++) rd(keyAt(i), tag);
  endtask

  initial begin
    #(5 * 150000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED1234));
    repeat (3) @(negedge clk);
    check("R1 in reset", storePulse, recallPulse, 0, 0);
    rstN = 1'b1;
    idle("R1 after reset");
    // R2 store
    prefix("R2"); rd(15'h0F0F, "R2 store"); idle("R8 one cycle");
    // R3 recall
    prefix("R3"); rd(15'h0F0E, "R3 recall"); idle("R8 one cycle");
    // R4 wrong address at step four, then the rest of the steps
    rd(15'h0000, "R4"); rd(15'h1555, "R4"); rd(15'h0AAA, "R4"); rd(15'h1234, "R4");
    rd(15'h1FFF, "R4"); rd(15'h10F0, "R4"); rd(15'h0F0F, "R4 no store");
    // R5 write mid-sequence; write together with read
    rd(15'h0000, "R5"); rd(15'h1555, "R5"); cyc(0, 1, 0, 15'h0, "R5");
    rd(15'h0AAA, "R5"); rd(15'h1FFF, "R5"); rd(15'h10F0, "R5"); rd(15'h0F0F, "R5 no store");
    prefix("R5"); cyc(1, 1, 0, 15'h0F0F, "R5 write wins");
    // R6 restart on 0x0000 after abort
    rd(15'h0000, "R6"); rd(15'h1555, "R6"); rd(15'h0000, "R6");
    rd(15'h1555, "R6"); rd(15'h0AAA, "R6"); rd(15'h1FFF, "R6"); rd(15'h10F0, "R6");
    rd(15'h0F0F, "R6 store");
    // R7 busy
    prefix("R7"); cyc(1, 0, 1, 15'h0F0F, "R7 busy read");
    prefix("R7"); cyc(0, 0, 1, 15'h0, "R7"); rd(15'h0F0E, "R7 no recall");
    // R8 idle gaps
    for (int i = 0; i < 5; i++) begin rd(keyAt(i), "R8"); idle("R8 gap"); idle("R8 gap"); end
    rd(15'h0F0E, "R8 recall after gaps"); idle("R8 one cycle");
    // R9 bit 14
    rd(15'h4000, "R9"); rd(15'h1555, "R9"); rd(15'h0AAA, "R9"); rd(15'h1FFF, "R9");
    rd(15'h10F0, "R9"); rd(15'h0F0F, "R9 no store");
    prefix("R9"); rd(15'h4F0F, "R9 no store");
    // R10 bad sixth, 0x0000 restarts
    prefix("R10"); rd(15'h0F0D, "R10 none");
    prefix("R10"); rd(15'h0000, "R10 restart");
    for (int i = 1; i < 5; i++) rd(keyAt(i), "R10");
    rd(15'h0F0E, "R10 recall");
    // Random stream
    for (int n = 0; n < 4000; n++) begin
      int r = int'($urandom_range(99));
      int k = int'($urandom_range(7));
      if (r < 4) cyc(0, 0, 1, keyAt(k), "R7 random");
      else if (r < 8) cyc($urandom_range(1), 1, 0, keyAt(k), "R5 random");
      else if (r < 20) idle("R8 random");
      else if (r < 55) rd(keyAt(mStep == 5 ? 5 + int'($urandom_range(1)) : mStep), "R2 R3 random");
      else rd(keyAt(k), "R4 random");
    end
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule